// File: doc/BRIEF.md
# Shared-Memory Character Fetch Sequencer

This block feeds a raster video pipeline from one 8-bit memory. The same memory holds the screen's character codes and the glyph bitmaps, and software can rewrite the glyphs. Each 8-pixel character cell takes two reads from that memory. The first read, on the first dot of the cell, fetches the character code at the cell address. The second read, on the fifth dot, fetches the glyph row that the code and the current scanline select. The fetched glyph byte enters a pixel shifter at the end of the cell and is shifted out, most significant bit first, during the following cell.

Bitmap graphics use the same path. In bitmap mode each framebuffer byte is treated as a code into a font that is one scanline tall, with a separate font base. The glyph read then returns the display byte itself, so no second output path is needed. The mode input takes effect only on a frame-start pulse. The memory is synchronous: read data is valid on the clock after the read strobe. The display-enable input covers the fetch window. Pixels of a cell appear one cell later, so upstream timing opens the window one cell early.

Top module: `cellfetch_seq`

## Requirements
- R1: After reset the read strobe and the pixel output are 0. The first dot enable inside an active window is the first slot of a cell and issues a code read.
- R2: On the first dot enable of each cell (slot 0), mem_rd is 1 and mem_addr equals cell_addr.
- R3: In text mode, on the fifth dot enable of a cell (slot 4), mem_rd is 1 and mem_addr = {TXT_BASE, code, scanline}. Here code is the byte read in slot 0 and occupies bits 11:4, and scanline occupies bits 3:0.
- R4: In bitmap mode the slot 4 read address is {BMP_BASE, code, 4'b0000}. The scanline input has no effect on it.
- R5: The mode register loads mode_in (0 = text, 1 = bitmap) only in a cycle where frame_start is 1. Changes of mode_in at other times do not change the addressing.
- R6: The glyph byte fetched for a cell loads into the shifter on the cell's eighth dot enable. During the next cell, pixel shows bit 7 first and then one lower bit on each following dot enable.
- R7: In active cycles without a dot enable the slot, the reads and the pixel output do not change.
- R8: While active is 0 no reads are issued and pixel is 0 from the next clock on. The slot count restarts at 0 when active returns.
- R9: Reads occur only on dot enables, exactly two per cell (slots 0 and 4), and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active | input | 1 | Fetch window enable |
| dot_en | input | 1 | One pulse per pixel |
| frame_start | input | 1 | Frame-start pulse that samples mode_in |
| mode_in | input | 1 | 0 text, 1 bitmap |
| cell_addr | input | ADDR_W | Memory address of the current cell's code |
| scanline | input | 4 | Row within the character |
| mem_rdata | input | 8 | Memory read data, valid the clock after mem_rd |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe |
| pixel | output | 1 | Serial pixel |

## Verification
The read strobe and address are combinational from the slot and the inputs. They are due in the same cycle as the dot enable that opens slot 0 or slot 4, and the bench samples them one nanosecond after it drives that cycle's inputs. The pixel is registered. A glyph byte loaded at a cell's last dot shows bit 7 in the cycle of the next cell's first dot, so the bench expects bit 7-i at dot i of the following cell. Random idle cycles let the bench check that the pixel holds between dot enables. The bench checks that the pixel goes dark one clock after active falls, and that a new mode applies only to lines after a frame-start pulse.

// File: rtl/cellfetch_pkg.sv
package cellfetch_pkg;

    localparam int CELL_PIX   = 8;
    localparam int SLOT_W     = $clog2(CELL_PIX);
    localparam int ROW_W      = 4;
    localparam int CODE_W     = 8;
    localparam int CODE_SLOT  = 0;
    localparam int GLYPH_SLOT = CELL_PIX / 2;

    typedef enum logic [1:0] {
        FETCH_NONE  = 2'd0,
        FETCH_CODE  = 2'd1,
        FETCH_GLYPH = 2'd2
    } fetch_kind_e;

    typedef enum logic {
        MODE_TEXT   = 1'b0,
        MODE_BITMAP = 1'b1
    } disp_mode_e;

    typedef struct packed {
        logic code_pend;
        logic glyph_pend;
    } fetch_pend_t;

    function automatic logic [ROW_W-1:0] row_select(input disp_mode_e m,
                                                    input logic [ROW_W-1:0] line);
        return (m == MODE_BITMAP) ? '0 : line;
    endfunction

endpackage

// File: rtl/cellfetch_slot_timer.sv
module cellfetch_slot_timer
    import cellfetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        dot_en,
    output fetch_kind_e kind,
    output logic        boundary
);
    logic [SLOT_W-1:0] slot_q;
    logic              step;

    assign step = active & dot_en;

    always_ff @(posedge clk) begin
        if (rst || !active)
            slot_q <= '0;
        else if (dot_en)
            slot_q <= slot_q + 1'b1;
    end

    always_comb begin
        kind = FETCH_NONE;
        if (step && slot_q == SLOT_W'(CODE_SLOT))
            kind = FETCH_CODE;
        else if (step && slot_q == SLOT_W'(GLYPH_SLOT))
            kind = FETCH_GLYPH;
    end

    assign boundary = step && (slot_q == SLOT_W'(CELL_PIX - 1));

endmodule

// File: rtl/cellfetch_addr_gen.sv
module cellfetch_addr_gen
    import cellfetch_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-13:0] TXT_BASE = 'h8,
    parameter logic [ADDR_W-13:0] BMP_BASE = 'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              mode_in,
    input  fetch_kind_e       kind,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [ROW_W-1:0]  scanline,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [7:0]        glyph_byte,
    output disp_mode_e        mode_q
);
    localparam int BASE_W = ADDR_W - CODE_W - ROW_W;

    fetch_pend_t           pend_q;
    logic [CODE_W-1:0]     code_q;
    logic [7:0]            glyph_q;
    logic [BASE_W-1:0]     base;
    logic [ADDR_W-1:0]     glyph_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_TEXT;
            pend_q  <= '0;
            code_q  <= '0;
            glyph_q <= '0;
        end else begin
            if (frame_start)
                mode_q <= disp_mode_e'(mode_in);
            pend_q.code_pend  <= (kind == FETCH_CODE);
            pend_q.glyph_pend <= (kind == FETCH_GLYPH);
            if (pend_q.code_pend)
                code_q <= mem_rdata;
            if (pend_q.glyph_pend)
                glyph_q <= mem_rdata;
        end
    end

    always_comb begin
        base       = (mode_q == MODE_BITMAP) ? BMP_BASE : TXT_BASE;
        glyph_addr = {base, code_q, row_select(mode_q, scanline)};
        mem_rd     = (kind != FETCH_NONE);
        mem_addr   = (kind == FETCH_GLYPH) ? glyph_addr : cell_addr;
    end

    assign glyph_byte = glyph_q;

endmodule

// File: rtl/cellfetch_shifter.sv
module cellfetch_shifter
    import cellfetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       dot_en,
    input  logic       boundary,
    input  logic [7:0] load_byte,
    output logic       pixel
);
    logic [CELL_PIX-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst || !active)
            sh_q <= '0;
        else if (boundary)
            sh_q <= load_byte;
        else if (dot_en)
            sh_q <= {sh_q[CELL_PIX-2:0], 1'b0};
    end

    assign pixel = sh_q[CELL_PIX-1];

endmodule

// File: rtl/cellfetch_seq.sv
module cellfetch_seq
    import cellfetch_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-13:0] TXT_BASE = 'h8,
    parameter logic [ADDR_W-13:0] BMP_BASE = 'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              dot_en,
    input  logic              frame_start,
    input  logic              mode_in,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [3:0]        scanline,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              pixel
);
    fetch_kind_e kind;
    logic        boundary;
    logic [7:0]  glyph_byte;
    disp_mode_e  mode_q;

    cellfetch_slot_timer u_slot (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .dot_en   (dot_en),
        .kind     (kind),
        .boundary (boundary)
    );

    cellfetch_addr_gen #(
        .ADDR_W   (ADDR_W),
        .TXT_BASE (TXT_BASE),
        .BMP_BASE (BMP_BASE)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .mode_in     (mode_in),
        .kind        (kind),
        .cell_addr   (cell_addr),
        .scanline    (scanline),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .glyph_byte  (glyph_byte),
        .mode_q      (mode_q)
    );

    cellfetch_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .dot_en    (dot_en),
        .boundary  (boundary),
        .load_byte (glyph_byte),
        .pixel     (pixel)
    );

endmodule

// File: rtl/cellfetch_seq_chk.sv
module cellfetch_seq_chk (
    input logic clk,
    input logic rst,
    input logic active,
    input logic dot_en,
    input logic frame_start,
    input logic mem_rd,
    input logic pixel,
    input logic mode_q
);
    // R8
    idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mem_rd);

    // R8
    idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !pixel);

    // R9
    read_on_dot_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> dot_en);

    // R9
    read_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(mode_q));

    // R7
    pixel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !dot_en) |=> $stable(pixel));

endmodule

bind cellfetch_seq cellfetch_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .dot_en      (dot_en),
    .frame_start (frame_start),
    .mem_rd      (mem_rd),
    .pixel       (pixel),
    .mode_q      (mode_q)
);

// File: tb/cellfetch_seq_bench.sv
`timescale 1ns/1ps
module cellfetch_seq_bench;
    localparam int AW = 16;
    localparam logic [3:0] TB_TXT = 4'h8;
    localparam logic [3:0] TB_BMP = 4'hC;

    logic          clk = 0;
    logic          rst = 1;
    logic          active = 0;
    logic          dot_en = 0;
    logic          frame_start = 0;
    logic          mode_in = 0;
    logic [AW-1:0] cell_addr = '0;
    logic [3:0]    scanline = '0;
    logic [7:0]    mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic          pixel;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  mode_exp = 0;

    always #2 clk = ~clk;

    cellfetch_seq #(.ADDR_W(AW), .TXT_BASE(TB_TXT), .BMP_BASE(TB_BMP)) u_cellfetch_seq (
        .clk(clk), .rst(rst), .active(active), .dot_en(dot_en),
        .frame_start(frame_start), .mode_in(mode_in), .cell_addr(cell_addr),
        .scanline(scanline), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .pixel(pixel)
    );

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h3C;
    endfunction

    function automatic logic [AW-1:0] gaddr(input logic [7:0] code,
                                            input logic [3:0] sl, input bit bmp);
        return bmp ? {TB_BMP, code, 4'h0} : {TB_TXT, code, sl};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic new_frame(input bit m);
        @(negedge clk); frame_start = 1; mode_in = m; dot_en = 0;
        @(negedge clk); frame_start = 0;
        mode_exp = m;
    endtask

    task automatic run_cell(input logic [AW-1:0] ca, input logic [3:0] sl,
                            input logic [7:0] prev, input bit gaps,
                            output logic [7:0] glyph);
        logic [7:0] code;
        code = '0; glyph = '0;
        for (int i = 0; i < 8; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                @(negedge clk); dot_en = 0; #1;
                chk(pixel == prev[7-i], "R7 hold", pixel, prev[7-i]);
                chk(!mem_rd, "R7 no read", mem_rd, 0);
            end
            @(negedge clk); dot_en = 1; cell_addr = ca; scanline = sl; #1;
            chk(pixel == prev[7-i], "R6 pixel", pixel, prev[7-i]);
            if (i == 0) begin
                chk(mem_rd && mem_addr == ca, "R2 code read", mem_addr, ca);
                code = memf(ca);
            end else if (i == 4) begin
                chk(mem_rd && mem_addr == gaddr(code, sl, mode_exp),
                    mode_exp ? "R4 bitmap read" : "R3 text read",
                    mem_addr, gaddr(code, sl, mode_exp));
                glyph = memf(gaddr(code, sl, mode_exp));
            end else begin
                chk(!mem_rd, "R9 no read", mem_rd, 0);
            end
        end
    endtask

    task automatic run_line(input logic [AW-1:0] start, input int ncells,
                            input logic [3:0] sl, input bit gaps);
        logic [7:0] prev, g;
        prev = '0;
        @(negedge clk); active = 1; dot_en = 0;
        for (int c = 0; c < ncells; c++) begin
            run_cell(start + AW'(c), sl, prev, gaps, g);
            prev = g;
        end
        @(negedge clk); active = 0; dot_en = 1; #1;
        chk(pixel == prev[7], "R6 last cell", pixel, prev[7]);
        chk(!mem_rd, "R8 idle read", mem_rd, 0);
        @(negedge clk); #1;
        chk(!pixel, "R8 idle dark", pixel, 0);
        dot_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_rd && !pixel, "R1 reset", {mem_rd, pixel}, 0);
        rst = 0;
        @(negedge clk); #1;
        chk(!mem_rd && !pixel, "R1 after reset", {mem_rd, pixel}, 0);
        new_frame(0);
        // R1 first dot is a code read
        run_line(16'h0100, 4, 4'd0, 0);
        run_line(16'h0340, 3, 4'd15, 0);
        // R7 random idle gaps
        for (int k = 0; k < 6; k++)
            run_line(16'($urandom), 1 + ($urandom % 5), 4'($urandom), 1);
        // R8 restart: abort mid-cell, slot count must return to 0
        @(negedge clk); active = 1; dot_en = 1; cell_addr = 16'h0777;
        repeat (3) @(negedge clk);
        active = 0; dot_en = 1;
        @(negedge clk); #1;
        chk(!mem_rd && !pixel, "R8 aborted cell", {mem_rd, pixel}, 0);
        dot_en = 0;
        run_line(16'h0900, 2, 4'd7, 0);
        // R5 mode change without frame start keeps text addressing
        @(negedge clk); mode_in = 1;
        run_line(16'h0A00, 2, 4'd9, 0);
        new_frame(1);
        // R4 bitmap, scanline must not matter
        run_line(16'h0B10, 3, 4'd11, 0);
        run_line(16'h0B10, 2, 4'd3, 1);
        for (int k = 0; k < 4; k++)
            run_line(16'($urandom), 1 + ($urandom % 4), 4'($urandom), 1);
        @(negedge clk); mode_in = 0;
        run_line(16'h0C00, 2, 4'd5, 0);
        new_frame(0);
        run_line(16'h0D00, 3, 4'd12, 1);
        summary();
    end
endmodule